// File: doc/BRIEF.md
# Online Synaptic Potential Accumulator

This block keeps, for each input synapse of a single spiking neuron, a running measure of how much that synapse's spike train has pushed the neuron's membrane potential towards its firing points. It works during the forward pass of training, one discrete time step at a time, so the spike history never has to be stored. Each synapse carries three quantities: a leaky synaptic trace, a leaky membrane-contribution term fed by that trace, and an accumulated potential. Whenever the neuron fires, each synapse's contribution term is folded into its accumulated potential and then cleared.

A neuron controller starts one time step by pulsing `step_go` together with the presynaptic spike vector and the neuron's fire bit for that step. One shared datapath then visits the synapses in index order, one per clock, and `step_done` marks the end of the sweep. The backward pass later reads the accumulated potentials through a registered read port. All quantities are unsigned fixed point with six fractional bits. Both decay constants are powers of two, so every division is a right shift.

Top module: `spk_contrib_accum`

## Requirements
- R1: On each processed step, a synapse's trace becomes p − (p >> SYN_SHIFT), plus 2^(6−SYN_SHIFT) (0.25 with the default shift of 2) when bit i of `pre_spk` was 1 for synapse i. The result saturates at the trace width maximum.
- R2: On the same step, after the trace update, the contribution term becomes q − (q >> MEM_SHIFT) + p, where p is the trace value just computed. The result saturates at the term width maximum.
- R3: When `post_fire` was 1 for the step, each synapse adds its newly computed contribution term into its accumulated potential, and the term is then stored as zero. When `post_fire` was 0, the accumulated potential is unchanged.
- R4: The accumulated potential is 11 bits wide with 6 fractional bits. Its sum saturates at 2047 and never wraps.
- R5: A step started with `first_step` = 1 treats the prior trace, contribution and accumulated potential of every synapse as zero. This starts a new training example.
- R6: An accepted step keeps `busy` high for exactly N_SYN cycles, one per synapse. `step_done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R7: A `step_go` pulse while `busy` is high is ignored. It alters no state and produces no extra `step_done`.
- R8: `rd_data` shows the accumulated potential of synapse `rd_addr` one clock after `rd_addr` is applied.
- R9: After reset, `busy` and `step_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_go | input | 1 | Request to process one time step; taken only when idle |
| first_step | input | 1 | The requested step is the first of a new example |
| pre_spk | input | N_SYN | Presynaptic spike bits for the step, bit i for synapse i |
| post_fire | input | 1 | The neuron fired in this step |
| rd_addr | input | IDX_W | Synapse index for the potential read port |
| busy | output | 1 | A step sweep is in progress |
| step_done | output | 1 | One-cycle pulse after the last synapse is written |
| rd_data | output | E_W | Accumulated potential of the addressed synapse, registered |

## Verification
The assertions rely on the default widths being large enough that, under the shift-based decay, the trace and contribution stay below their limits. Only the accumulated potential then reaches its ceiling, so an unspiked trace can only decay and a potential can only grow within an example. They also rely on `step_go`, `pre_spk`, `post_fire` and `first_step` being held steady around the accepting edge. The bench changes inputs only on falling edges. It starts every example with `first_step` set, so no stale or uninitialised memory value reaches the checks. It reads the potentials only while the block is idle.

// File: rtl/spk_acc_pkg.sv
package spk_acc_pkg;
  typedef enum logic [0:0] {SEQ_IDLE, SEQ_RUN} seq_state_t;
endpackage

// File: rtl/leak_stage.sv
module leak_stage #(
  parameter int W     = 12,
  parameter int SH    = 2,
  parameter int ADD_W = 12
) (
  input  logic [W-1:0]     cur,
  input  logic [ADD_W-1:0] add_in,
  output logic [W-1:0]     nxt
);
  localparam logic [W:0] MAXV = {1'b0, {W{1'b1}}};

  logic [W-1:0] decayed;
  logic [W:0]   sum;

  always_comb begin
    decayed = cur - (cur >> SH);
    sum     = {1'b0, decayed} + (W+1)'(add_in);
    nxt     = (sum > MAXV) ? {W{1'b1}} : sum[W-1:0];
  end
endmodule

// File: rtl/sat_accum.sv
module sat_accum #(
  parameter int EW = 11,
  parameter int QW = 14
) (
  input  logic          en,
  input  logic [EW-1:0] e_in,
  input  logic [QW-1:0] q_in,
  output logic [EW-1:0] e_out
);
  localparam int SW = ((EW > QW) ? EW : QW) + 1;
  localparam logic [SW-1:0] EMAX = SW'({EW{1'b1}});

  logic [SW-1:0] sum;

  always_comb begin
    sum = SW'(e_in) + SW'(q_in);
    if (!en)
      e_out = e_in;
    else if (sum > EMAX)
      e_out = {EW{1'b1}};
    else
      e_out = sum[EW-1:0];
  end
endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
  import spk_acc_pkg::*;
#(
  parameter int N_SYN = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_go,
  output logic             accept,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             step_done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SYN - 1);

  seq_state_t state;

  assign busy   = (state == SEQ_RUN);
  assign accept = (state == SEQ_IDLE) && step_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      idx       <= '0;
      step_done <= 1'b0;
    end else begin
      step_done <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (step_go) begin
            state <= SEQ_RUN;
            idx   <= '0;
          end
        end
        default: begin
          if (idx == LAST) begin
            state     <= SEQ_IDLE;
            step_done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spk_contrib_accum.sv
module spk_contrib_accum #(
  parameter int N_SYN     = 8,
  parameter int E_W       = 11,
  parameter int E_FRAC    = 6,
  parameter int P_W       = 12,
  parameter int Q_W       = 14,
  parameter int SYN_SHIFT = 2,
  parameter int MEM_SHIFT = 3,
  localparam int IDX_W    = (N_SYN > 1) ? $clog2(N_SYN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_go,
  input  logic             first_step,
  input  logic [N_SYN-1:0] pre_spk,
  input  logic             post_fire,
  input  logic [IDX_W-1:0] rd_addr,
  output logic             busy,
  output logic             step_done,
  output logic [E_W-1:0]   rd_data
);
  localparam int SPK_INC_I = 1 << (E_FRAC - SYN_SHIFT);
  localparam logic [P_W-1:0] SPK_INC = P_W'(SPK_INC_I);

  logic [P_W-1:0] p_mem [N_SYN];
  logic [Q_W-1:0] q_mem [N_SYN];
  logic [E_W-1:0] e_mem [N_SYN];

  logic             accept;
  logic [IDX_W-1:0] idx;
  logic [N_SYN-1:0] spk_l;
  logic             fire_l;
  logic             first_l;

  logic             spk_bit;
  logic             wr_en;
  logic [P_W-1:0]   p_cur, p_nxt, p_add;
  logic [Q_W-1:0]   q_cur, q_lk, q_wr;
  logic [E_W-1:0]   e_cur, e_nxt;

  step_sequencer #(.N_SYN(N_SYN), .IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .step_go  (step_go),
    .accept   (accept),
    .busy     (busy),
    .idx      (idx),
    .step_done(step_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      spk_l   <= '0;
      fire_l  <= 1'b0;
      first_l <= 1'b0;
    end else if (accept) begin
      spk_l   <= pre_spk;
      fire_l  <= post_fire;
      first_l <= first_step;
    end
  end

  assign wr_en   = busy;
  assign spk_bit = spk_l[idx];
  assign p_cur   = first_l ? '0 : p_mem[idx];
  assign q_cur   = first_l ? '0 : q_mem[idx];
  assign e_cur   = first_l ? '0 : e_mem[idx];
  assign p_add   = spk_bit ? SPK_INC : '0;

  leak_stage #(.W(P_W), .SH(SYN_SHIFT), .ADD_W(P_W)) u_trace (
    .cur   (p_cur),
    .add_in(p_add),
    .nxt   (p_nxt)
  );

  leak_stage #(.W(Q_W), .SH(MEM_SHIFT), .ADD_W(P_W)) u_contrib (
    .cur   (q_cur),
    .add_in(p_nxt),
    .nxt   (q_lk)
  );

  sat_accum #(.EW(E_W), .QW(Q_W)) u_acc (
    .en   (fire_l),
    .e_in (e_cur),
    .q_in (q_lk),
    .e_out(e_nxt)
  );

  assign q_wr = fire_l ? '0 : q_lk;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      p_mem[idx] <= p_nxt;
      q_mem[idx] <= q_wr;
      e_mem[idx] <= e_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= e_mem[rd_addr];
  end
endmodule

// File: rtl/spk_contrib_accum_chk.sv
module spk_contrib_accum_chk #(
  parameter int N_SYN = 8,
  parameter int P_W   = 12,
  parameter int E_W   = 11,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             step_done,
  input logic             wr_en,
  input logic             spk_bit,
  input logic [IDX_W-1:0] idx,
  input logic [P_W-1:0]   p_cur,
  input logic [P_W-1:0]   p_nxt,
  input logic [E_W-1:0]   e_cur,
  input logic [E_W-1:0]   e_nxt
);
  localparam int CW = $clog2(N_SYN + 1) + 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SYN - 1);

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)       busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  // R1: with no spike the trace can only decay
  p_trace_decay_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !spk_bit) |-> (p_nxt <= p_cur));

  // R4: the potential never wraps below its previous value
  p_e_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (e_nxt >= e_cur));

  // R6: a sweep lasts exactly one cycle per synapse
  p_step_len_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(busy)) |-> (busy_cnt == CW'(N_SYN)));

  // R6: done is a single pulse aligned with busy falling
  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    step_done |-> (!busy && $past(busy)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    step_done |=> !step_done);

  // R7: a sweep is not cut short or restarted before its last synapse
  p_busy_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && idx != LAST) |=> (busy && idx == $past(idx) + 1'b1));
endmodule

bind spk_contrib_accum spk_contrib_accum_chk #(
  .N_SYN(N_SYN), .P_W(P_W), .E_W(E_W), .IDX_W(IDX_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .step_done(step_done),
  .wr_en    (wr_en),
  .spk_bit  (spk_bit),
  .idx      (idx),
  .p_cur    (p_cur),
  .p_nxt    (p_nxt),
  .e_cur    (e_cur),
  .e_nxt    (e_nxt)
);

// File: tb/spk_contrib_accum_test.sv
module spk_contrib_accum_test;
  localparam int N_SYN = 8;
  localparam int IDX_W = 3;
  localparam int PMAX  = 4095;
  localparam int QMAX  = 16383;
  localparam int EMAX  = 2047;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             step_go = 1'b0;
  logic             first_step = 1'b0;
  logic [N_SYN-1:0] pre_spk = '0;
  logic             post_fire = 1'b0;
  logic [IDX_W-1:0] rd_addr = '0;
  logic             busy, step_done;
  logic [10:0]      rd_data;

  int checks = 0;
  int errors = 0;
  int steps_taken = 0;
  int done_seen = 0;
  bit finished = 1'b0;

  int mp[N_SYN];
  int mq[N_SYN];
  int me[N_SYN];
  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  spk_contrib_accum uut (
    .clk(clk), .rst(rst), .step_go(step_go), .first_step(first_step),
    .pre_spk(pre_spk), .post_fire(post_fire), .rd_addr(rd_addr),
    .busy(busy), .step_done(step_done), .rd_data(rd_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // reference model of one step (R1, R2, R3, R4, R5)
  task automatic model_step(input logic [N_SYN-1:0] spk, input bit fire, input bit first);
    for (int i = 0; i < N_SYN; i++) begin
      int p, q, e;
      p = first ? 0 : mp[i];
      q = first ? 0 : mq[i];
      e = first ? 0 : me[i];
      p = p - (p >> 2) + (spk[i] ? 16 : 0);
      if (p > PMAX) p = PMAX;
      q = q - (q >> 3) + p;
      if (q > QMAX) q = QMAX;
      if (fire) begin
        e = e + q;
        if (e > EMAX) e = EMAX;
        q = 0;
      end
      mp[i] = p; mq[i] = q; me[i] = e;
    end
  endtask

  // driver: issue a step and push expected potentials
  task automatic do_step(input logic [N_SYN-1:0] spk, input bit fire, input bit first,
                         input string tag, input bit poke);
    @(negedge clk);
    step_go = 1'b1; pre_spk = spk; post_fire = fire; first_step = first;
    @(negedge clk);
    step_go = 1'b0; pre_spk = '0; post_fire = 1'b0; first_step = 1'b0;
    steps_taken++;
    model_step(spk, fire, first);
    for (int i = 0; i < N_SYN; i++) begin
      exp_q.push_back(me[i]);
      tag_q.push_back(tag);
    end
    if (poke) begin
      // R7: requests while busy must be dropped
      @(negedge clk);
      step_go = 1'b1; pre_spk = '1; post_fire = 1'b1; first_step = 1'b1;
      repeat (2) @(negedge clk);
      step_go = 1'b0; pre_spk = '0; post_fire = 1'b0; first_step = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor: after each sweep read every synapse and compare (R8)
  initial begin
    forever begin
      @(negedge clk);
      if (step_done) begin
        done_seen++;
        for (int i = 0; i < N_SYN; i++) begin
          rd_addr = IDX_W'(i);
          @(negedge clk);
          if (exp_q.size() == 0) begin
            check("R8 unexpected result", int'(rd_data), -1);
          end else begin
            string t;
            int ev;
            ev = exp_q.pop_front();
            t  = tag_q.pop_front();
            check($sformatf("%s R8 syn%0d", t, i), int'(rd_data), ev);
          end
        end
      end
    end
  end

  // R6: busy length and done alignment
  initial begin
    int cnt = 0;
    bit prev = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (busy) cnt++;
        if (prev && !busy) begin
          check("R6 busy cycles", cnt, N_SYN);
          check("R6 done with busy fall", int'(step_done), 1);
          cnt = 0;
        end
        prev = busy;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 busy after reset", int'(busy), 0);
    check("R9 done after reset", int'(step_done), 0);

    // R1/R2: traces build up with no firing, potentials stay zero (R3)
    do_step(8'b1010_0101, 1'b0, 1'b1, "R1 R3 no-fire first", 1'b0);
    do_step(8'b1100_0011, 1'b0, 1'b0, "R2 R3 no-fire", 1'b0);
    do_step(8'b0000_0000, 1'b0, 1'b0, "R1 decay", 1'b0);
    // R3: firing captures contributions
    do_step(8'b1111_0000, 1'b1, 1'b0, "R3 fire capture", 1'b0);
    do_step(8'b0101_0101, 1'b0, 1'b0, "R3 hold after fire", 1'b0);
    do_step(8'b0011_1100, 1'b1, 1'b0, "R2 R3 second fire", 1'b0);
    // R7: a step request during the sweep is ignored
    do_step(8'b1000_0001, 1'b1, 1'b0, "R7 busy poke", 1'b1);
    // R5: new example clears state
    do_step(8'b0000_0001, 1'b1, 1'b1, "R5 new example", 1'b0);
    // R4: sustained spiking and firing saturates the potential
    for (int k = 0; k < 45; k++)
      do_step(8'b1111_1110, 1'b1, 1'b0, "R4 saturation", 1'b0);
    check("R4 model reached ceiling", me[1], EMAX);
    // long silent build-up of q, then one fire
    do_step(8'b0110_0110, 1'b0, 1'b1, "R5 restart", 1'b0);
    for (int k = 0; k < 12; k++)
      do_step(8'b0110_0110, 1'b0, 1'b0, "R2 build-up", 1'b0);
    do_step(8'b0000_0000, 1'b1, 1'b0, "R2 R3 late fire", 1'b0);

    repeat (5) @(negedge clk);
    check("R7 step_done count", done_seen, steps_taken);
    check("R8 queue drained", exp_q.size(), 0);
    summary();
  end
endmodule